// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block decides, for every framed command reaching a 512 KB serial NOR flash, whether that command may take effect. A front end that has already shifted in the opcode, the target address, an optional status byte and the number of serial clocks seen before chip-select rose presents them on a one-cycle `cmd_valid` strobe. One cycle later the gate answers with an accept flag and a flag saying whether the address lies in the currently protected range. The gate also holds the state that drives those decisions: the write-enable latch, the four block-protect bits, the status-lock bit, a one-time-programmable lock bit, the deep power-down state, the busy state of an array operation and the two suspend flags.

The protected range is always a whole number of 64 KB blocks. One block-protect bit selects whether the range grows down from the top of the array or up from address zero. The other three select its size. A status-lock bit, combined with the write-protect pin, freezes the status bits. A power-up window blocks every modifying command for a set number of clocks after reset. The array itself, its program and erase timing, and the serial shifter are outside this block. A completion strobe, `op_done`, stands in for them.

Top module: `flash_wp_gate`

## Requirements
- R1: A modifying command (Write Status, Page Program, Sector Erase, Half Block Erase, Block Erase, Chip Erase) is rejected unless `cmd_cnt` is an exact multiple of eight.
- R2: A modifying command is rejected unless the write-enable latch `wel` is 1. An accepted Write Enable sets `wel` to 1.
- R3: `wel` is 0 after reset. It is cleared by an accepted Write Disable, by an accepted Write Status, and by the `op_done` that finishes an accepted program or erase. A rejected command leaves `wel` unchanged.
- R4: With `bp[3]`=0, the protected blocks are counted down from the top of the array. The block index is `cmd_addr[18:16]`. For `bp[2:0]` values 0 to 7, the number of protected blocks is 0, 1, 2, 4, 6, 7, 8 and 8.
- R5: With `bp[3]`=1, the same numbers of blocks are counted up from block 0.
- R6: Page Program, Sector Erase, Half Block Erase and Block Erase are rejected when their address is protected. Chip Erase is rejected whenever the protected range is not empty. `resp_prot` reports the protection of `cmd_addr` for every command.
- R7: An accepted Enter Deep Power-down sets `deep_pd`. While `deep_pd` is 1, every command except Release is rejected and changes no state. Release is always accepted and clears `deep_pd`.
- R8: When `srp`=1 and `wp_n`=0, Write Status is rejected, and `bp` and `srp` keep their values.
- R9: An accepted Write Status with `otp_mode`=0 loads `cmd_data[3:0]` into `bp` and `cmd_data[7]` into `srp`. With `otp_mode`=1, it ignores `cmd_data` and sets `otp_lock` to 1.
- R10: Every modifying command is rejected while fewer than `PUW_CYC` clock edges have passed since reset was released.
- R11: Suspend is accepted only while an operation runs unsuspended. It sets `sus_ers` for an erase and `sus_pgm` for a program. Resume is accepted only while suspended and clears both flags.
- R12: While `busy` is 1, including while suspended, modifying commands are rejected. `op_done` ends the operation only when it is not suspended.
- R13: `resp_valid` follows `cmd_valid` by exactly one cycle. `resp_accept` and `resp_prot` are 0 whenever `resp_valid` is 0. Opcodes are: 0 Write Enable, 1 Write Disable, 2 Write Status, 3 Page Program, 4 Sector Erase, 5 Half Block Erase, 6 Block Erase, 7 Chip Erase, 8 Enter Deep Power-down, 9 Release, 10 Suspend, 11 Resume, 12 Read. Codes 13 to 15 are always rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a framed command is present |
| cmd_op | input | 4 | Command code (see R13) |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | 8 | Status byte for Write Status |
| cmd_cnt | input | CNT_W | Serial clocks counted before chip-select rose |
| wp_n | input | 1 | Write-protect pin, active low |
| otp_mode | input | 1 | One-time-programmable mode is active |
| op_done | input | 1 | Array program or erase has finished |
| resp_valid | output | 1 | Decision is present |
| resp_accept | output | 1 | Command accepted |
| resp_prot | output | 1 | Command address is protected |
| wel | output | 1 | Write-enable latch |
| bp | output | 4 | Block-protect bits |
| srp | output | 1 | Status-lock bit |
| otp_lock | output | 1 | One-time-programmable area locked |
| deep_pd | output | 1 | Deep power-down state |
| busy | output | 1 | Program or erase in progress |
| sus_ers | output | 1 | Erase suspended |
| sus_pgm | output | 1 | Program suspended |

## Verification
The bench builds the gate with `PUW_CYC` = 16 and keeps the default 19-bit address, 3-bit block index and 8-bit clock count. The short power-up window lets the first commands after reset fall inside the blocked interval while still leaving room for a long run afterwards. The default geometry lets the bench sweep all sixteen block-protect settings against every 64 KB block and check the protection flag of each.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

  typedef enum logic [3:0] {
    OP_WREN = 4'd0,
    OP_WRDI = 4'd1,
    OP_WRSR = 4'd2,
    OP_PP   = 4'd3,
    OP_SE   = 4'd4,
    OP_HBE  = 4'd5,
    OP_BE   = 4'd6,
    OP_CE   = 4'd7,
    OP_DPD  = 4'd8,
    OP_RDP  = 4'd9,
    OP_SUSP = 4'd10,
    OP_RESM = 4'd11,
    OP_READ = 4'd12
  } fwg_op_e;

  // State changes that an accepted command requests.
  typedef struct packed {
    logic set_wel;
    logic clr_wel;
    logic load_sr;
    logic lock_otp;
    logic start_pgm;
    logic start_ers;
    logic enter_dpd;
    logic leave_dpd;
    logic do_susp;
    logic do_resm;
  } fwg_fx_t;

  function automatic logic op_modifies(input fwg_op_e op);
    return (op == OP_WRSR) || (op == OP_PP) || (op == OP_SE) ||
           (op == OP_HBE) || (op == OP_BE) || (op == OP_CE);
  endfunction

endpackage

// File: rtl/fwg_puw_timer.sv
// Counts clock edges after reset up to PUW_CYC, then holds.
module fwg_puw_timer #(
  parameter int unsigned PUW_CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CW = $clog2(PUW_CYC + 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          adv;

  assign done = (cnt_q == CW'(PUW_CYC));
  assign adv  = !done;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/fwg_prot_decode.sv
// Maps the block-protect bits and an address to a protection hit.
module fwg_prot_decode #(
  parameter int ADDR_W = 19,
  parameter int BLK_W  = 3
) (
  input  logic [3:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              any
);
  localparam int NBLK   = 1 << BLK_W;
  localparam int BLK_SH = ADDR_W - BLK_W;

  logic [3:0]     eighths;
  logic [BLK_W:0] nprot;
  logic [BLK_W:0] blk;
  logic [BLK_W:0] first_up;

  always_comb begin
    case (bp[2:0])
      3'd0:    eighths = 4'd0;
      3'd1:    eighths = 4'd1;
      3'd2:    eighths = 4'd2;
      3'd3:    eighths = 4'd4;
      3'd4:    eighths = 4'd6;
      3'd5:    eighths = 4'd7;
      default: eighths = 4'd8;
    endcase
    nprot    = (BLK_W+1)'((int'(eighths) * NBLK) / 8);
    blk      = (BLK_W+1)'(addr >> BLK_SH);
    first_up = (BLK_W+1)'(NBLK) - nprot;
    any      = (nprot != '0);
    hit      = bp[3] ? (blk < nprot) : (blk >= first_up);
  end
endmodule

// File: rtl/fwg_decide.sv
// Combinational acceptance rules for one framed command.
module fwg_decide
  import fwg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  fwg_op_e           op,
  input  logic [CNT_W-1:0]  clk_cnt,
  input  logic              puw_done,
  input  logic              wp_n,
  input  logic              otp_mode,
  input  logic              hit,
  input  logic              any,
  input  logic              wel,
  input  logic              srp,
  input  logic              dpd,
  input  logic              busy,
  input  logic              susp_any,
  output logic              accept,
  output fwg_fx_t           fx
);
  logic byte_ok;
  logic mod_ok;

  always_comb begin
    accept  = 1'b0;
    fx      = '0;
    byte_ok = ((clk_cnt & CNT_W'(7)) == '0);
    mod_ok  = !dpd && puw_done && byte_ok && wel && !busy;
    case (op)
      OP_WREN: begin
        accept     = !dpd;
        fx.set_wel = !dpd;
      end
      OP_WRDI: begin
        accept     = !dpd;
        fx.clr_wel = !dpd;
      end
      OP_WRSR: begin
        accept      = mod_ok && !(srp && !wp_n);
        fx.clr_wel  = accept;
        fx.lock_otp = accept && otp_mode;
        fx.load_sr  = accept && !otp_mode;
      end
      OP_PP: begin
        accept       = mod_ok && !hit;
        fx.start_pgm = accept;
      end
      OP_SE, OP_HBE, OP_BE: begin
        accept       = mod_ok && !hit;
        fx.start_ers = accept;
      end
      OP_CE: begin
        accept       = mod_ok && !any;
        fx.start_ers = accept;
      end
      OP_DPD: begin
        accept       = !dpd;
        fx.enter_dpd = !dpd;
      end
      OP_RDP: begin
        accept       = 1'b1;
        fx.leave_dpd = 1'b1;
      end
      OP_SUSP: begin
        accept     = !dpd && busy && !susp_any;
        fx.do_susp = accept;
      end
      OP_RESM: begin
        accept     = !dpd && susp_any;
        fx.do_resm = accept;
      end
      OP_READ: begin
        accept = !dpd;
      end
      default: begin
        accept = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fwg_status.sv
// Holds latch, protect, power and suspend state.
module fwg_status
  import fwg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt,
  input  fwg_fx_t    fx,
  input  logic [7:0] sr_data,
  input  logic       op_done,
  output logic       wel,
  output logic [3:0] bp,
  output logic       srp,
  output logic       otp_lock,
  output logic       dpd,
  output logic       busy,
  output logic       sus_ers,
  output logic       sus_pgm
);
  logic       wel_q, wel_d;
  logic [3:0] bp_q, bp_d;
  logic       srp_q, srp_d;
  logic       otp_q, otp_d;
  logic       dpd_q, dpd_d;
  logic       busy_q, busy_d;
  logic       ers_q, ers_d;
  logic       se_q, se_d;
  logic       sp_q, sp_d;
  logic       done_ev;
  logic       upd;

  assign done_ev = op_done && busy_q && !(se_q || sp_q);
  assign upd     = evt || done_ev;

  always_comb begin
    wel_d  = wel_q;
    bp_d   = bp_q;
    srp_d  = srp_q;
    otp_d  = otp_q;
    dpd_d  = dpd_q;
    busy_d = busy_q;
    ers_d  = ers_q;
    se_d   = se_q;
    sp_d   = sp_q;
    if (done_ev) begin
      busy_d = 1'b0;
      wel_d  = 1'b0;
    end
    if (evt) begin
      if (fx.set_wel) wel_d = 1'b1;
      if (fx.clr_wel) wel_d = 1'b0;
      if (fx.load_sr) begin
        bp_d  = 4'(sr_data);
        srp_d = sr_data[7];
      end
      if (fx.lock_otp) otp_d = 1'b1;
      if (fx.start_pgm) begin
        busy_d = 1'b1;
        ers_d  = 1'b0;
      end
      if (fx.start_ers) begin
        busy_d = 1'b1;
        ers_d  = 1'b1;
      end
      if (fx.enter_dpd) dpd_d = 1'b1;
      if (fx.leave_dpd) dpd_d = 1'b0;
      if (fx.do_susp) begin
        if (ers_q) se_d = 1'b1;
        else       sp_d = 1'b1;
      end
      if (fx.do_resm) begin
        se_d = 1'b0;
        sp_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      bp_q   <= 4'd0;
      srp_q  <= 1'b0;
      otp_q  <= 1'b0;
      dpd_q  <= 1'b0;
      busy_q <= 1'b0;
      ers_q  <= 1'b0;
      se_q   <= 1'b0;
      sp_q   <= 1'b0;
    end else if (upd) begin
      wel_q  <= wel_d;
      bp_q   <= bp_d;
      srp_q  <= srp_d;
      otp_q  <= otp_d;
      dpd_q  <= dpd_d;
      busy_q <= busy_d;
      ers_q  <= ers_d;
      se_q   <= se_d;
      sp_q   <= sp_d;
    end
  end

  assign wel      = wel_q;
  assign bp       = bp_q;
  assign srp      = srp_q;
  assign otp_lock = otp_q;
  assign dpd      = dpd_q;
  assign busy     = busy_q;
  assign sus_ers  = se_q;
  assign sus_pgm  = sp_q;
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
  import fwg_pkg::*;
#(
  parameter int          ADDR_W  = 19,
  parameter int          BLK_W   = 3,
  parameter int          CNT_W   = 8,
  parameter int unsigned PUW_CYC = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [CNT_W-1:0]  cmd_cnt,
  input  logic              wp_n,
  input  logic              otp_mode,
  input  logic              op_done,
  output logic              resp_valid,
  output logic              resp_accept,
  output logic              resp_prot,
  output logic              wel,
  output logic [3:0]        bp,
  output logic              srp,
  output logic              otp_lock,
  output logic              deep_pd,
  output logic              busy,
  output logic              sus_ers,
  output logic              sus_pgm
);
  fwg_op_e op_e;
  fwg_fx_t fx;
  logic    puw_done;
  logic    hit;
  logic    any;
  logic    accept;
  logic    evt;
  logic    rv_q, rv_d;
  logic    ra_q, ra_d;
  logic    rp_q, rp_d;

  assign op_e = fwg_op_e'(cmd_op);
  assign evt  = cmd_valid && accept;

  fwg_puw_timer #(.PUW_CYC(PUW_CYC)) u_puw (
    .clk  (clk),
    .rst_n(rst_n),
    .done (puw_done)
  );

  fwg_prot_decode #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dec (
    .bp  (bp),
    .addr(cmd_addr),
    .hit (hit),
    .any (any)
  );

  fwg_decide #(.CNT_W(CNT_W)) u_dcd (
    .op      (op_e),
    .clk_cnt (cmd_cnt),
    .puw_done(puw_done),
    .wp_n    (wp_n),
    .otp_mode(otp_mode),
    .hit     (hit),
    .any     (any),
    .wel     (wel),
    .srp     (srp),
    .dpd     (deep_pd),
    .busy    (busy),
    .susp_any(sus_ers || sus_pgm),
    .accept  (accept),
    .fx      (fx)
  );

  fwg_status u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .fx      (fx),
    .sr_data (cmd_data),
    .op_done (op_done),
    .wel     (wel),
    .bp      (bp),
    .srp     (srp),
    .otp_lock(otp_lock),
    .dpd     (deep_pd),
    .busy    (busy),
    .sus_ers (sus_ers),
    .sus_pgm (sus_pgm)
  );

  always_comb begin
    rv_d = cmd_valid;
    ra_d = cmd_valid && accept;
    rp_d = cmd_valid && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      ra_q <= 1'b0;
      rp_q <= 1'b0;
    end else begin
      rv_q <= rv_d;
      ra_q <= ra_d;
      rp_q <= rp_d;
    end
  end

  assign resp_valid  = rv_q;
  assign resp_accept = ra_q;
  assign resp_prot   = rp_q;
endmodule

// File: rtl/flash_wp_gate_chk.sv
module flash_wp_gate_chk
  import fwg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [3:0]       cmd_op,
  input logic [CNT_W-1:0] cmd_cnt,
  input logic             wp_n,
  input logic             otp_mode,
  input logic             op_done,
  input logic             resp_valid,
  input logic             resp_accept,
  input logic             resp_prot,
  input logic             wel,
  input logic [3:0]       bp,
  input logic             srp,
  input logic             deep_pd,
  input logic             busy,
  input logic             sus_ers,
  input logic             sus_pgm
);
  logic is_mod;
  assign is_mod = op_modifies(fwg_op_e'(cmd_op));

  a_r1_byte_multiple: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && is_mod && ((cmd_cnt % 8) != 0) |=> !resp_accept);

  a_r2_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && is_mod && !wel |=> !resp_accept);

  a_r3_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_WRDI) && !deep_pd |=> !wel);

  a_r7_dpd_filter: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && deep_pd && (cmd_op != OP_RDP) |=> !resp_accept);

  a_r8_wp_lock: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_WRSR) && srp && !wp_n |=> $stable(bp) && $stable(srp));

  a_r9_otp_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_WRSR) && otp_mode |=> $stable(bp) && $stable(srp));

  a_r11_one_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    !(sus_ers && sus_pgm));

  a_r11_suspend_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sus_ers) || $rose(sus_pgm) |-> $past(cmd_valid) && ($past(cmd_op) == OP_SUSP));

  a_r12_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(op_done) && !$past(sus_ers) && !$past(sus_pgm));

  a_r13_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> !resp_accept && !resp_prot);
endmodule

bind flash_wp_gate flash_wp_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_cnt    (cmd_cnt),
  .wp_n       (wp_n),
  .otp_mode   (otp_mode),
  .op_done    (op_done),
  .resp_valid (resp_valid),
  .resp_accept(resp_accept),
  .resp_prot  (resp_prot),
  .wel        (wel),
  .bp         (bp),
  .srp        (srp),
  .deep_pd    (deep_pd),
  .busy       (busy),
  .sus_ers    (sus_ers),
  .sus_pgm    (sus_pgm)
);

// File: tb/flash_wp_gate_tb.sv
module flash_wp_gate_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PUW    = 16;
  localparam int ADDR_W = 19;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_valid;
  logic [3:0]        cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_data;
  logic [CNT_W-1:0]  cmd_cnt;
  logic              wp_n;
  logic              otp_mode;
  logic              op_done;
  logic              resp_valid, resp_accept, resp_prot;
  logic              wel, srp, otp_lock, deep_pd, busy, sus_ers, sus_pgm;
  logic [3:0]        bp;

  int    vectors = 0;
  int    errs    = 0;
  bit    finished = 0;
  string cur_req  = "R3";

  // reference state
  int m_wel, m_bp, m_srp, m_otp, m_dpd, m_busy, m_ers, m_se, m_sp;
  int m_rv, m_ra, m_rp, edges;

  always #2.5 clk = ~clk;

  flash_wp_gate #(.ADDR_W(ADDR_W), .BLK_W(3), .CNT_W(CNT_W), .PUW_CYC(PUW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_cnt(cmd_cnt), .wp_n(wp_n),
    .otp_mode(otp_mode), .op_done(op_done), .resp_valid(resp_valid),
    .resp_accept(resp_accept), .resp_prot(resp_prot), .wel(wel), .bp(bp),
    .srp(srp), .otp_lock(otp_lock), .deep_pd(deep_pd), .busy(busy),
    .sus_ers(sus_ers), .sus_pgm(sus_pgm)
  );

  function automatic int prot_kb(int code);
    case (code & 7)
      0: return 0;
      1: return 64;
      2: return 128;
      3: return 256;
      4: return 384;
      5: return 448;
      default: return 512;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int op, a, lo, hi, size, acc, hit, pre, pwok;
    int n_wel, n_bp, n_srp, n_otp, n_dpd, n_busy, n_ers, n_se, n_sp;
    if (!rst_n) begin
      m_wel = 0; m_bp = 0; m_srp = 0; m_otp = 0; m_dpd = 0; m_busy = 0;
      m_ers = 0; m_se = 0; m_sp = 0; m_rv = 0; m_ra = 0; m_rp = 0; edges = 0;
    end else begin
      pwok  = (edges >= PUW) ? 1 : 0;
      edges = edges + 1;
      op    = int'(cmd_op);
      a     = int'(cmd_addr);
      size  = prot_kb(m_bp) * 1024;
      if ((m_bp & 8) != 0) begin lo = 0; hi = size; end
      else begin lo = 512 * 1024 - size; hi = 512 * 1024; end
      hit = (size != 0 && a >= lo && a < hi) ? 1 : 0;
      pre = (!m_dpd && pwok && (int'(cmd_cnt) % 8 == 0) && m_wel && !m_busy) ? 1 : 0;
      n_wel = m_wel; n_bp = m_bp; n_srp = m_srp; n_otp = m_otp; n_dpd = m_dpd;
      n_busy = m_busy; n_ers = m_ers; n_se = m_se; n_sp = m_sp;
      if (op_done && m_busy && !m_se && !m_sp) begin
        n_busy = 0; n_wel = 0;
      end
      acc = 0;
      if (cmd_valid) begin
        case (op)
          0: begin acc = !m_dpd; if (acc) n_wel = 1; end
          1: begin acc = !m_dpd; if (acc) n_wel = 0; end
          2: begin
            acc = pre && !(m_srp && !wp_n);
            if (acc) begin
              n_wel = 0;
              if (otp_mode) n_otp = 1;
              else begin n_bp = int'(cmd_data) % 16; n_srp = int'(cmd_data) / 128; end
            end
          end
          3: begin acc = pre && !hit; if (acc) begin n_busy = 1; n_ers = 0; end end
          4, 5, 6: begin acc = pre && !hit; if (acc) begin n_busy = 1; n_ers = 1; end end
          7: begin acc = pre && (size == 0); if (acc) begin n_busy = 1; n_ers = 1; end end
          8: begin acc = !m_dpd; if (acc) n_dpd = 1; end
          9: begin acc = 1; n_dpd = 0; end
          10: begin
            acc = !m_dpd && m_busy && !m_se && !m_sp;
            if (acc) begin if (m_ers) n_se = 1; else n_sp = 1; end
          end
          11: begin acc = !m_dpd && (m_se || m_sp); if (acc) begin n_se = 0; n_sp = 0; end end
          12: acc = !m_dpd;
          default: acc = 0;
        endcase
      end
      m_rv = cmd_valid ? 1 : 0;
      m_ra = (cmd_valid && acc) ? 1 : 0;
      m_rp = (cmd_valid && hit) ? 1 : 0;
      m_wel = n_wel; m_bp = n_bp; m_srp = n_srp; m_otp = n_otp; m_dpd = n_dpd;
      m_busy = n_busy; m_ers = n_ers; m_se = n_se; m_sp = n_sp;
    end
  end

  task automatic chk(string nm, int act, int exp);
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s got %0d expected %0d", cur_req, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      vectors++;
      chk("resp_valid",  int'(resp_valid),  m_rv);
      chk("resp_accept", int'(resp_accept), m_ra);
      chk("resp_prot",   int'(resp_prot),   m_rp);
      chk("wel",         int'(wel),         m_wel);
      chk("bp",          int'(bp),          m_bp);
      chk("srp",         int'(srp),         m_srp);
      chk("otp_lock",    int'(otp_lock),    m_otp);
      chk("deep_pd",     int'(deep_pd),     m_dpd);
      chk("busy",        int'(busy),        m_busy);
      chk("sus_ers",     int'(sus_ers),     m_se);
      chk("sus_pgm",     int'(sus_pgm),     m_sp);
    end
  end

  task automatic send(int op, int addr, int data, int cnt);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 4'(op);
    cmd_addr  = ADDR_W'(addr);
    cmd_data  = 8'(data);
    cmd_cnt   = CNT_W'(cnt);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_op();
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0;
    cmd_cnt = '0; wp_n = 1'b1; otp_mode = 1'b0; op_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: inside the power-up window
    cur_req = "R10";
    send(0, 0, 0, 8);
    send(3, 32'h100, 0, 32);
    send(4, 32'h100, 0, 32);
    repeat (20) @(negedge clk);
    // R2: no latch, no modify
    cur_req = "R2";
    send(1, 0, 0, 8);
    send(3, 32'h100, 0, 32);
    // R1: clock count not a multiple of eight
    cur_req = "R1";
    send(0, 0, 0, 8);
    send(3, 32'h100, 0, 33);
    send(2, 0, 8'h01, 15);
    send(4, 32'h2000, 0, 31);
    send(3, 32'h100, 0, 40);
    // R12: busy blocks further modify
    cur_req = "R12";
    send(0, 0, 0, 8);
    send(4, 32'h3000, 0, 32);
    send(2, 0, 8'h02, 16);
    // R3: completion clears the latch
    cur_req = "R3";
    finish_op();
    // R11: suspend and resume
    cur_req = "R11";
    send(10, 0, 0, 8);
    send(0, 0, 0, 8);
    send(4, 32'h4000, 0, 32);
    send(10, 0, 0, 8);
    cur_req = "R12";
    finish_op();
    send(3, 32'h100, 0, 32);
    cur_req = "R11";
    send(11, 0, 0, 8);
    finish_op();
    send(0, 0, 0, 8);
    send(3, 32'h200, 0, 32);
    send(10, 0, 0, 8);
    send(10, 0, 0, 8);
    send(11, 0, 0, 8);
    finish_op();
    send(11, 0, 0, 8);
    // R4, R5, R6: protect sweep
    for (int b = 0; b < 16; b++) begin
      cur_req = "R9";
      send(0, 0, 0, 8);
      send(2, 0, b, 16);
      cur_req = (b >= 8) ? "R5" : "R4";
      for (int k = 0; k < 8; k++) send(12, k * 65536 + 32'h1234, 0, 8);
      cur_req = "R6";
      send(0, 0, 0, 8);
      send(3, 32'h00100, 0, 40);
      finish_op();
      send(0, 0, 0, 8);
      send(4, 32'h7F000, 0, 32);
      finish_op();
      send(0, 0, 0, 8);
      send(5, 32'h38000, 0, 32);
      finish_op();
      send(0, 0, 0, 8);
      send(7, 0, 0, 8);
      finish_op();
    end
    // R8: write-protect pin with status lock
    cur_req = "R8";
    send(0, 0, 0, 8);
    send(2, 0, 8'h83, 16);
    wp_n = 1'b0;
    send(0, 0, 0, 8);
    send(2, 0, 8'h00, 16);
    wp_n = 1'b1;
    send(2, 0, 8'h00, 16);
    // R9: one-time-programmable lock
    cur_req = "R9";
    otp_mode = 1'b1;
    send(0, 0, 0, 8);
    send(2, 0, 8'h85, 16);
    otp_mode = 1'b0;
    // R7: deep power-down filtering
    cur_req = "R7";
    send(8, 0, 0, 8);
    send(0, 0, 0, 8);
    send(12, 0, 0, 8);
    send(8, 0, 0, 8);
    send(9, 0, 0, 8);
    send(0, 0, 0, 8);
    send(9, 0, 0, 8);
    // R13: undefined codes
    cur_req = "R13";
    send(13, 0, 0, 8);
    send(15, 0, 0, 8);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errs++;
      $display("FAIL R13 watchdog expired got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule